// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a small synchronous register file. Software writes an output value and a per-pin output enable, and reads back the level seen at each pad after synchronization. Each pin can also latch an interrupt event. The event is either a level (low or high), a single edge (rising or falling), or both edges through a per-pin override. Latched events sit in a write-1-to-clear status word. A mask word gates them onto two combined interrupt lines, one for the lower half of the pins and one for the upper half.

The register interface has an address, a write strobe with write data, and a read strobe. A read returns its data one cycle later and holds it until the next read. Pad inputs pass through a two-stage synchronizer, and the synchronized value feeds both the pad-status register and the trigger logic. The block has no sequencing state machine. Its behaviour per pin is chosen by one of five trigger modes: low level, high level, rising edge, falling edge, and the both-edge override, which takes priority over the other four.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers decode at byte offsets 0x00 output data, 0x04 output enable, 0x08 pad status, 0x0C trigger word for pins 0–15, 0x10 trigger word for pins 16–31, 0x14 interrupt mask, 0x18 interrupt status, 0x1C both-edge select. Any other offset, including one with address bits [1:0] non-zero, reads as zero and ignores writes.
- R2: After reset every writable register reads zero, `pad_oe_o` and `pad_out_o` are all zero, and both interrupt outputs are low.
- R3: `pad_oe_o` equals the output-enable register (1 = pin driven) and `pad_out_o` equals the output-data register, both updating on the clock edge that performs the write.
- R4: The pad-status register returns every pin's level after two synchronizing flops, whatever the pin's direction. A pad change made just before a read is not yet visible to that read.
- R5: Pin n's 2-bit trigger code sits at bits [2*(n mod 16)+1 : 2*(n mod 16)] of the lower trigger word (n < 16) or the upper word (n >= 16). Code 00 sets status while the synchronized pin is low, and 01 sets it while the pin is high.
- R6: Code 10 sets status on a synchronized rising edge and code 11 on a falling edge. The opposite edge sets nothing.
- R7: When a pin's both-edge select bit is 1, its trigger code is ignored and status is set on either edge, never on a steady level.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Status bits are never cleared any other way.
- R9: A level-triggered pin whose condition still holds keeps its status bit set through a clear, because a set in the same cycle as a clear wins.
- R10: Status bits latch whether or not the pin is masked. The mask affects only the interrupt outputs.
- R11: `irq_lo_o` is high exactly when some bit 0–15 of status AND mask is 1, and `irq_hi_o` does the same for bits 16–31.
- R12: `rd_data_o` takes the addressed value on the clock edge where `rd_en_i` is high and holds it while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| pad_in_i | input | 32 | Pad levels, asynchronous |
| pad_out_o | output | 32 | Output value per pin |
| pad_oe_o | output | 32 | Output enable per pin |
| irq_lo_o | output | 1 | Combined interrupt, pins 0–15 |
| irq_hi_o | output | 1 | Combined interrupt, pins 16–31 |

## Verification
The assertions assume that reset is released between clock edges. They also assume that strobes and address are steady around each edge. Each property that looks one cycle back is guarded by the previous cycle being out of reset, so values captured while reset was held never count. The bench changes pads, strobes and address only on the falling clock edge. It never issues a read and a write in the same cycle. Its random phase keeps addresses within and just beyond the mapped window, so both decoded and unmapped accesses are exercised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_PAD  = 3'd2,
        REG_CFGL = 3'd3,
        REG_CFGH = 3'd4,
        REG_MASK = 3'd5,
        REG_STAT = 3'd6,
        REG_BOTH = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } addr_dec_t;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int PINS = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] cur_o,
    output logic [PINS-1:0] prev_o
);
    logic [PINS-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pad_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign cur_o  = stage2_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] cur_i,
    input  logic [PINS-1:0] prev_i,
    input  logic [PINS-1:0] cfg_lo_i,
    input  logic [PINS-1:0] cfg_hi_i,
    input  logic [PINS-1:0] both_i,
    output logic [PINS-1:0] hit_o
);
    localparam int HALF = PINS / 2;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        trig_e mode;
        logic  rise, fall, pin_hit;

        if (p < HALF) begin : g_lo
            assign mode = trig_e'(cfg_lo_i[2*p +: 2]);
        end else begin : g_hi
            assign mode = trig_e'(cfg_hi_i[2*(p-HALF) +: 2]);
        end

        assign rise = cur_i[p] & ~prev_i[p];
        assign fall = ~cur_i[p] & prev_i[p];

        always_comb begin
            if (both_i[p]) begin
                pin_hit = rise | fall;
            end else begin
                unique case (mode)
                    TRIG_LOW:  pin_hit = ~cur_i[p];
                    TRIG_HIGH: pin_hit = cur_i[p];
                    TRIG_RISE: pin_hit = rise;
                    TRIG_FALL: pin_hit = fall;
                    default:   pin_hit = 1'b0;
                endcase
            end
        end

        assign hit_o[p] = pin_hit;
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int PINS = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PINS-1:0] hit_i,
    input  logic            clr_we_i,
    input  logic [PINS-1:0] clr_data_i,
    input  logic [PINS-1:0] mask_i,
    output logic [PINS-1:0] status_o,
    output logic            irq_lo_o,
    output logic            irq_hi_o
);
    localparam int HALF = PINS / 2;

    logic [PINS-1:0] status_q, clr_eff, pending;

    assign clr_eff = clr_we_i ? clr_data_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= (status_q & ~clr_eff) | hit_i;
    end

    assign pending  = status_q & mask_i;
    assign irq_lo_o = |pending[HALF-1:0];
    assign irq_hi_o = |pending[PINS-1:HALF];
    assign status_o = status_q;

    // R10: a trigger event latches regardless of mask
    p_event_latches_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (($past(hit_i) & ~status_q) == '0));

    // R8: a written 1 clears the bit unless an event coincides
    p_w1c_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(clr_we_i)) |->
            ((status_q & $past(clr_data_i) & ~$past(hit_i)) == '0));

    // R8: nothing but a written 1 drops a status bit
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (($past(status_q) & ~status_q & ~$past(clr_eff)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32,
    parameter int AW   = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_en_i,
    input  logic [PINS-1:0] wr_data_i,
    input  logic            rd_en_i,
    output logic [PINS-1:0] rd_data_o,
    input  logic [PINS-1:0] pad_in_i,
    output logic [PINS-1:0] pad_out_o,
    output logic [PINS-1:0] pad_oe_o,
    output logic            irq_lo_o,
    output logic            irq_hi_o
);
    localparam int HALF    = PINS / 2;
    localparam int SEL_LSB = 2;
    localparam int WIN_LSB = SEL_LSB + 3;

    function automatic addr_dec_t decode_addr(input logic [AW-1:0] a);
        addr_dec_t d;
        d.hit = (a[SEL_LSB-1:0] == '0) && ((a >> WIN_LSB) == '0);
        d.sel = reg_sel_e'(a[WIN_LSB-1:SEL_LSB]);
        return d;
    endfunction

    addr_dec_t       dec;
    logic            wr_hit, clr_we;
    logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q;
    logic [PINS-1:0] pad_cur, pad_prev, hit, status;
    logic [PINS-1:0] rd_next, rd_q;

    assign dec    = decode_addr(addr_i);
    assign wr_hit = wr_en_i && dec.hit;
    assign clr_we = wr_hit && (dec.sel == REG_STAT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_hit) begin
            unique case (dec.sel)
                REG_DATA: data_q   <= wr_data_i;
                REG_DIR:  dir_q    <= wr_data_i;
                REG_CFGL: cfg_lo_q <= wr_data_i;
                REG_CFGH: cfg_hi_q <= wr_data_i;
                REG_MASK: mask_q   <= wr_data_i;
                REG_BOTH: both_q   <= wr_data_i;
                REG_PAD, REG_STAT: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                REG_DATA: rd_next = data_q;
                REG_DIR:  rd_next = dir_q;
                REG_PAD:  rd_next = pad_cur;
                REG_CFGL: rd_next = cfg_lo_q;
                REG_CFGH: rd_next = cfg_hi_q;
                REG_MASK: rd_next = mask_q;
                REG_STAT: rd_next = status;
                REG_BOTH: rd_next = both_q;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_next;
    end

    gpio_pad_sync #(.PINS(PINS)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pad_i (pad_in_i),
        .cur_o (pad_cur),
        .prev_o(pad_prev)
    );

    gpio_trig_detect #(.PINS(PINS)) u_trig (
        .cur_i   (pad_cur),
        .prev_i  (pad_prev),
        .cfg_lo_i(cfg_lo_q),
        .cfg_hi_i(cfg_hi_q),
        .both_i  (both_q),
        .hit_o   (hit)
    );

    gpio_irq_status #(.PINS(PINS)) u_stat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (hit),
        .clr_we_i  (clr_we),
        .clr_data_i(wr_data_i),
        .mask_i    (mask_q),
        .status_o  (status),
        .irq_lo_o  (irq_lo_o),
        .irq_hi_o  (irq_hi_o)
    );

    assign rd_data_o = rd_q;
    assign pad_out_o = data_q;
    assign pad_oe_o  = dir_q;

    // R1: unmapped reads return zero
    p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !dec.hit) |=> (rd_data_o == '0));

    // R12: read data holds without a read strobe
    p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(rd_en_i)) |-> $stable(rd_data_o));

    // R10/R11: with the lower half fully masked, the lower line stays low
    p_lo_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q[HALF-1:0] == '0) |-> !irq_lo_o);

    // R11: upper line likewise
    p_hi_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q[PINS-1:HALF] == '0) |-> !irq_hi_o);
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    localparam int PINS = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wdata = '0;
    logic            rd_en = 1'b0;
    logic [31:0]     rdata;
    logic [31:0]     pad = '0;
    logic [31:0]     pad_out, pad_oe;
    logic            irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port #(.PINS(PINS), .AW(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
        .pad_in_i(pad), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
    );

    // Behavioural reference model
    logic [31:0] m_dr = 0, m_dir = 0, m_c1 = 0, m_c2 = 0, m_mask = 0;
    logic [31:0] m_stat = 0, m_both = 0, m_rd = 0;
    logic [31:0] hist[$] = '{32'h0, 32'h0, 32'h0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dr = 0; m_dir = 0; m_c1 = 0; m_c2 = 0; m_mask = 0;
            m_stat = 0; m_both = 0; m_rd = 0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] cur, prv, ev, clr;
            logic        mapped;
            cur = hist[1];
            prv = hist[2];
            ev  = 0;
            for (int n = 0; n < 32; n++) begin
                int code;
                code = (n < 16) ? int'((m_c1 >> (2*n)) & 3) : int'((m_c2 >> (2*(n-16))) & 3);
                if (m_both[n])      ev[n] = cur[n] != prv[n];
                else if (code == 0) ev[n] = !cur[n];
                else if (code == 1) ev[n] = cur[n];
                else if (code == 2) ev[n] = cur[n] && !prv[n];
                else                ev[n] = !cur[n] && prv[n];
            end
            mapped = (addr[1:0] == 0) && (addr < 8'h20);
            if (rd_en) begin
                if (!mapped) m_rd = 0;
                else case (addr[4:2])
                    0: m_rd = m_dr;   1: m_rd = m_dir;  2: m_rd = cur;
                    3: m_rd = m_c1;   4: m_rd = m_c2;   5: m_rd = m_mask;
                    6: m_rd = m_stat; default: m_rd = m_both;
                endcase
            end
            clr = (wr_en && mapped && addr[4:2] == 6) ? wdata : 0;
            m_stat = (m_stat & ~clr) | ev;
            if (wr_en && mapped) case (addr[4:2])
                0: m_dr = wdata;  1: m_dir = wdata;  3: m_c1 = wdata;
                4: m_c2 = wdata;  5: m_mask = wdata; 7: m_both = wdata;
                default: ;
            endcase
            hist.push_front(pad);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 pad_out", pad_out, m_dr);
            chk("R3 pad_oe", pad_oe, m_dir);
            chk("R11 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_stat[15:0] & m_mask[15:0])});
            chk("R11 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_stat[31:16] & m_mask[31:16])});
            chk("R12 rd_data", rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R2 reset state
        chk("R2 pad_oe", pad_oe, 0);
        chk("R2 pad_out", pad_out, 0);
        chk("R2 irq", {30'b0, irq_hi, irq_lo}, 0);
        rd(8'h00, v); chk("R2 data", v, 0);
        rd(8'h04, v); chk("R2 dir", v, 0);
        rd(8'h0C, v); chk("R2 cfg lo", v, 0);
        rd(8'h14, v); chk("R2 mask", v, 0);
        rd(8'h1C, v); chk("R2 both", v, 0);
        // R3 output path, R1 readback
        wr(8'h00, 32'hA5A5F00F);
        wr(8'h04, 32'hFFFF0000);
        chk("R3 out", pad_out, 32'hA5A5F00F);
        chk("R3 oe", pad_oe, 32'hFFFF0000);
        rd(8'h00, v); chk("R1 data", v, 32'hA5A5F00F);
        rd(8'h04, v); chk("R1 dir", v, 32'hFFFF0000);
        // R4 pad status, independent of direction, two-flop latency
        pad = 32'h12345678;
        wait_cyc(3);
        rd(8'h08, v); chk("R4 pad", v, 32'h12345678);
        pad = 32'h0000FFFF;
        rd(8'h08, v); chk("R4 latency", v, 32'h12345678);
        wait_cyc(2);
        rd(8'h08, v); chk("R4 pad new", v, 32'h0000FFFF);
        // R1 unmapped
        rd(8'h20, v); chk("R1 unmapped", v, 0);
        rd(8'h02, v); chk("R1 misaligned", v, 0);
        wr(8'h21, 32'hFFFFFFFF);
        rd(8'h00, v); chk("R1 write ignored", v, 32'hA5A5F00F);
        // Configure all pins rising, clear status
        pad = 0;
        wr(8'h0C, 32'hAAAAAAAA);
        wr(8'h10, 32'hAAAAAAAA);
        wait_cyc(4);
        wr(8'h18, 32'hFFFFFFFF);
        rd(8'h18, v); chk("R8 cleared", v, 0);
        // R6 rising edges on pins 3 and 20
        pad = 32'h00100008;
        wait_cyc(4);
        rd(8'h18, v); chk("R6 rise", v, 32'h00100008);
        chk("R10 masked", {30'b0, irq_hi, irq_lo}, 0);
        // R11 halves
        wr(8'h14, 32'h00000008);
        chk("R11 lo", {30'b0, irq_hi, irq_lo}, 2'b01);
        wr(8'h14, 32'h00100008);
        chk("R11 hi", {30'b0, irq_hi, irq_lo}, 2'b11);
        // R8 write-0 and write-1
        wr(8'h18, 0);
        rd(8'h18, v); chk("R8 write0", v, 32'h00100008);
        wr(8'h18, 32'h00000008);
        chk("R8 irq_lo cleared", {31'b0, irq_lo}, 0);
        rd(8'h18, v); chk("R8 w1c", v, 32'h00100000);
        // R6 falling edge on pin 3
        wr(8'h0C, 32'hAAAAAAEA);
        pad = 32'h00100000;
        wait_cyc(4);
        rd(8'h18, v); chk("R6 fall", v & 32'h8, 32'h8);
        wr(8'h18, 32'h8);
        pad = 32'h00100008;
        wait_cyc(4);
        rd(8'h18, v); chk("R6 rise ignored", v & 32'h8, 0);
        // R5 high level on pin 5, R9 clear while held
        wr(8'h0C, 32'hAAAAA6EA);
        pad = pad | 32'h20;
        wait_cyc(4);
        rd(8'h18, v); chk("R5 high level", v & 32'h20, 32'h20);
        wr(8'h18, 32'h20);
        rd(8'h18, v); chk("R9 held", v & 32'h20, 32'h20);
        pad = pad & ~32'h20;
        wait_cyc(4);
        wr(8'h18, 32'h20);
        rd(8'h18, v); chk("R9 released", v & 32'h20, 0);
        // R5 low level on pin 18 (upper word)
        wr(8'h10, 32'hAAAAAA8A);
        wait_cyc(3);
        rd(8'h18, v); chk("R5 low level", v & 32'h40000, 32'h40000);
        wr(8'h10, 32'hAAAAAAAA);
        wr(8'h18, 32'h40000);
        rd(8'h18, v); chk("R5 low cleared", v & 32'h40000, 0);
        // R7 both-edge override on pin 7 (code set to high level)
        wr(8'h0C, 32'hAAAA66EA);
        wr(8'h1C, 32'h80);
        pad = pad | 32'h80;
        wait_cyc(4);
        rd(8'h18, v); chk("R7 rise", v & 32'h80, 32'h80);
        wr(8'h18, 32'h80);
        wait_cyc(2);
        rd(8'h18, v); chk("R7 level ignored", v & 32'h80, 0);
        pad = pad & ~32'h80;
        wait_cyc(4);
        rd(8'h18, v); chk("R7 fall", v & 32'h80, 32'h80);
        chk("R10 unmasked latch, no irq", {31'b0, irq_lo}, 0);
        // R12 hold
        pad = 32'hFFFFFFFF;
        wait_cyc(4);
        chk("R12 hold", rdata, v);
        // Random phase, checked against the model every cycle
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            pad   = $urandom;
            addr  = 8'($urandom_range(0, 9) * 4) | 8'(($urandom_range(0, 7) == 0) ? 1 : 0);
            wdata = $urandom;
            wr_en = ($urandom_range(0, 3) == 0);
            rd_en = !wr_en && ($urandom_range(0, 1) == 0);
        end
        @(negedge clk); wr_en = 0; rd_en = 0;
        wait_cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule